// File: doc/BRIEF.md
# Write-Once Snooping Coherence Controller

This block keeps one private cache coherent on a shared snooping bus under an invalidate scheme with a twist. The first write to a clean line is written through to memory as a single word. The line then enters a reserved state. A second write upgrades it to dirty with no bus activity. A reserved line can be dropped without a write-back, because memory still holds its value. The controller holds a small direct-mapped tag and data array with four-word blocks. It serves processor reads, writes and caller-signalled evictions. It watches the bus for read misses, write misses and single-word writes issued by other caches.

The processor holds `cpu_req` with its operation and address until `cpu_ack` pulses. The controller requests the bus when it needs to, waits for a grant, and then moves one word per cycle. For block fills, the bus returns four beats on `bus_rdata`. When a snooped miss hits a line held dirty, the controller raises the memory-inhibit signal and drives the four words on the supply port, in offset order 0 to 3. Memory captures the same beats as a write-back. Snoops that hit are served before any processor request. The caller evicts a frame before reusing it for a different tag.

Top module: `wo_coherence_ctrl`

## Requirements
- R1: At reset every line is INVALID. `cpu_ack`, `bus_req` and `snp_inhibit` are low, and the first read of any address after reset is a miss.
- R2: A snooped read miss (snoop command 1) that hits a DIRTY line raises `snp_inhibit`. It then supplies the four block words on `sup_data`, offsets 0 to 3 in order, one beat per cycle, which memory also captures. The line ends VALID, so a later local write to it goes through to memory.
- R3: A write hit on a DIRTY or RESERVED line completes with no bus request, and `cpu_ack` comes one cycle after acceptance. A RESERVED line becomes DIRTY.
- R4: A write hit on a VALID line issues a single word write (bus command 3), carrying the word address and the write data in exactly one beat. The line then becomes RESERVED.
- R5: A write miss issues bus command 2 and fills four beats. The processor word is merged into the fill, and the line becomes DIRTY.
- R6: An eviction (processor operation 2) of a DIRTY line issues a four-beat write-back (bus command 4) of the whole block. Eviction of a VALID or RESERVED line uses no bus. In every case the line is INVALID afterwards.
- R7: A snooped write miss (command 2) on a DIRTY line supplies the block and then invalidates it. A snooped write miss, or a snooped word write (command 3), on a VALID or RESERVED line invalidates it with no supply.
- R8: When a snoop hits in the same cycle as an idle processor request, the snoop is handled first. The processor acknowledgement is delayed by at least one cycle.
- R9: A read (operation 0) that hits returns the word one cycle after acceptance, with no bus traffic and no state change. A read miss issues bus command 1, fills four beats, and leaves the line VALID.
- R10: A snoop whose block address does not match the held tag leaves the line and its data untouched.
- R11: A snooped read miss on a RESERVED line moves it to VALID with no supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict |
| cpu_addr | input | AW | Word address {tag, index, offset} |
| cpu_wdata | input | DW | Write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read data, valid with `cpu_ack` |
| bus_req | output | 1 | Bus request, held through the transfer |
| bus_gnt | input | 1 | Bus grant pulse |
| bus_cmd | output | 3 | 1 read miss, 2 write miss, 3 word write, 4 write-back |
| bus_addr | output | AW | Word address (word write) or block base address |
| bus_wvalid | output | 1 | Outgoing write beat valid |
| bus_wdata | output | DW | Outgoing write beat |
| bus_rvalid | input | 1 | Incoming fill beat valid |
| bus_rdata | input | DW | Incoming fill beat |
| snp_valid | input | 1 | Snooped transaction strobe |
| snp_cmd | input | 3 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | AW-2 | Snooped block address {tag, index} |
| snp_inhibit | output | 1 | Memory inhibit while this cache supplies |
| sup_valid | output | 1 | Supplied beat valid |
| sup_data | output | DW | Supplied block word |

## Verification
Some behaviours are checked by assertions on every cycle. A word write-through only ever leaves a VALID line and lasts one beat. Supply starts only after a snooped miss. Owned-line writes and clean evictions finish without the bus, and a snoop hit delays a same-cycle processor request. Other behaviours only the bench scenarios can show, because each needs a chain of operations with the result observed later. These are: the reserved line's silent drop, the downgrade to VALID after a supplied read, the invalidation and re-fetch of new data after a foreign word write, the merge of write data into a fill, and the match of written-back memory against the expected values.

// File: rtl/wo_coherence_ctrl.sv
module wo_coherence_ctrl #(
  parameter int TAG_W = 2,
  parameter int IDX_W = 2,
  parameter int DW    = 16,
  localparam int AW   = TAG_W + IDX_W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic [1:0]    cpu_op,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ack,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [2:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic          bus_wvalid,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_rvalid,
  input  logic [DW-1:0] bus_rdata,
  input  logic          snp_valid,
  input  logic [2:0]    snp_cmd,
  input  logic [AW-3:0] snp_addr,
  output logic          snp_inhibit,
  output logic          sup_valid,
  output logic [DW-1:0] sup_data
);
  localparam int LINES = 1 << IDX_W;
  localparam logic [2:0] C_RD = 3'd1, C_WM = 3'd2, C_WW = 3'd3, C_WB = 3'd4;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2;

  typedef enum logic [1:0] {L_INV, L_VAL, L_RES, L_DIR} lstate_t;
  typedef enum logic [2:0] {S_IDLE, S_REQ, S_XFER, S_SUPPLY, S_DONE} fsm_t;

  lstate_t          lst  [LINES];
  logic [TAG_W-1:0] tags [LINES];
  logic [DW-1:0]    dat  [LINES*4];

  fsm_t             st;
  logic [2:0]       cmd;
  logic [1:0]       beat;
  logic [IDX_W-1:0] sidx;
  lstate_t          snew;
  logic [DW-1:0]    rdata_q;

  wire [TAG_W-1:0] ctag   = cpu_addr[AW-1 -: TAG_W];
  wire [IDX_W-1:0] cidx   = cpu_addr[2 +: IDX_W];
  wire [1:0]       coff   = cpu_addr[1:0];
  wire [TAG_W-1:0] stag   = snp_addr[AW-3 -: TAG_W];
  wire [IDX_W-1:0] sidx_w = snp_addr[IDX_W-1:0];

  wire chit      = lst[cidx] != L_INV && tags[cidx] == ctag;
  wire shit      = snp_valid && lst[sidx_w] != L_INV && tags[sidx_w] == stag;
  wire snoop_win = st == S_IDLE || st == S_REQ || st == S_DONE;

  assign cpu_ack     = st == S_DONE;
  assign cpu_rdata   = rdata_q;
  assign bus_req     = st == S_REQ || st == S_XFER;
  assign bus_cmd     = bus_req ? cmd : 3'd0;
  assign bus_addr    = cmd == C_WW ? cpu_addr
                     : cmd == C_WB ? {tags[cidx], cidx, 2'b00}
                     : {cpu_addr[AW-1:2], 2'b00};
  assign bus_wvalid  = st == S_XFER && (cmd == C_WW || cmd == C_WB);
  assign bus_wdata   = cmd == C_WW ? cpu_wdata : dat[{cidx, beat}];
  assign snp_inhibit = st == S_SUPPLY;
  assign sup_valid   = st == S_SUPPLY;
  assign sup_data    = dat[{sidx, beat}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cmd     <= 3'd0;
      beat    <= 2'd0;
      sidx    <= '0;
      snew    <= L_INV;
      rdata_q <= '0;
      for (int i = 0; i < LINES; i++) lst[i] <= L_INV;
    end else if (shit && snoop_win) begin
      st <= S_IDLE;
      case (snp_cmd)
        C_RD: if (lst[sidx_w] == L_DIR) begin
                st <= S_SUPPLY; snew <= L_VAL; sidx <= sidx_w; beat <= 2'd0;
              end else lst[sidx_w] <= L_VAL;
        C_WM: if (lst[sidx_w] == L_DIR) begin
                st <= S_SUPPLY; snew <= L_INV; sidx <= sidx_w; beat <= 2'd0;
              end else lst[sidx_w] <= L_INV;
        C_WW: lst[sidx_w] <= L_INV;
        default: ;
      endcase
    end else begin
      case (st)
        S_IDLE: if (cpu_req) begin
          beat <= 2'd0;
          case (cpu_op)
            OP_RD: if (chit) begin
                     rdata_q <= dat[{cidx, coff}]; st <= S_DONE;
                   end else begin cmd <= C_RD; st <= S_REQ; end
            OP_WR: if (chit && lst[cidx] != L_VAL) begin
                     dat[{cidx, coff}] <= cpu_wdata; lst[cidx] <= L_DIR; st <= S_DONE;
                   end else begin cmd <= chit ? C_WW : C_WM; st <= S_REQ; end
            default: if (lst[cidx] == L_DIR) begin cmd <= C_WB; st <= S_REQ; end
                     else begin lst[cidx] <= L_INV; st <= S_DONE; end
          endcase
        end
        S_REQ: if (bus_gnt) st <= S_XFER;
        S_XFER:
          if (cmd == C_WW) begin
            dat[{cidx, coff}] <= cpu_wdata;
            lst[cidx] <= L_RES;
            st <= S_DONE;
          end else if (cmd == C_WB) begin
            beat <= beat + 2'd1;
            if (beat == 2'd3) begin lst[cidx] <= L_INV; st <= S_DONE; end
          end else if (bus_rvalid) begin
            dat[{cidx, beat}] <= (cmd == C_WM && beat == coff) ? cpu_wdata : bus_rdata;
            if (beat == coff) rdata_q <= bus_rdata;
            beat <= beat + 2'd1;
            if (beat == 2'd3) begin
              tags[cidx] <= ctag;
              lst[cidx]  <= (cmd == C_WM) ? L_DIR : L_VAL;
              st <= S_DONE;
            end
          end
        S_SUPPLY: begin
          beat <= beat + 2'd1;
          if (beat == 2'd3) begin lst[sidx] <= snew; st <= S_IDLE; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_WT_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wvalid && bus_cmd == C_WW) |-> lst[cidx] == L_VAL); // R4
  AST_WT_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wvalid && bus_cmd == C_WW) |=> !bus_wvalid); // R4
  AST_SUPPLY_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snp_inhibit) |-> $past(snp_valid && (snp_cmd == C_RD || snp_cmd == C_WM))); // R2
  AST_OWNED_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cpu_req && cpu_op == OP_WR && chit && lst[cidx] != L_VAL && !shit)
    |=> cpu_ack && !bus_req); // R3
  AST_CLEAN_EVICT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cpu_req && cpu_op == OP_EV && lst[cidx] != L_DIR && !shit)
    |=> cpu_ack && !bus_req); // R6
  AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && shit && cpu_req) |=> !cpu_ack); // R8
endmodule

// File: tb/test_wo_coherence_ctrl.sv
module test_wo_coherence_ctrl;
  localparam int CLK_P = 10;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0; logic [1:0] cpu_op = 0; logic [5:0] cpu_addr = 0; logic [15:0] cpu_wdata = 0;
  logic cpu_ack; logic [15:0] cpu_rdata;
  logic bus_req, bus_gnt = 0, bus_wvalid, bus_rvalid = 0;
  logic [2:0] bus_cmd; logic [5:0] bus_addr; logic [15:0] bus_wdata, bus_rdata = 0;
  logic snp_valid = 0; logic [2:0] snp_cmd = 0; logic [3:0] snp_addr = 0;
  logic snp_inhibit, sup_valid; logic [15:0] sup_data;

  wo_coherence_ctrl i_wo_coherence_ctrl (.*);

  always #(CLK_P/2) clk = ~clk;

  logic [15:0] mem [64];
  logic [15:0] shadow [64];
  int n_cmd [8];
  int checks = 0, fails = 0;
  int bst = 0, bcnt = 0, bbeat = 0; logic [2:0] bcmd = 0; logic [5:0] baddr = 0;
  logic [5:0] sup_base = 0; int supk = 0, sup_beats = 0, sup_bad = 0;
  logic [15:0] rd; int lat;

  function automatic int tot();
    return n_cmd[1] + n_cmd[2] + n_cmd[3] + n_cmd[4];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  always @(negedge clk) begin
    bus_gnt = 0; bus_rvalid = 0;
    if (sup_valid) begin
      if (sup_data != shadow[6'(sup_base + supk)]) sup_bad++;
      mem[6'(sup_base + supk)] = sup_data; supk++; sup_beats++;
    end else supk = 0;
    if (!rst_n) begin bst = 0; bcnt = 0; end
    else if (bst == 0) begin
      if (bus_req) begin
        bcnt++;
        if (bcnt == 2) begin
          bus_gnt = 1; bcmd = bus_cmd; baddr = bus_addr; bst = 1; bbeat = 0; n_cmd[bus_cmd]++;
        end
      end else bcnt = 0;
    end else begin
      if (bcmd == 3'd1 || bcmd == 3'd2) begin
        if (bbeat < 4) begin
          bus_rvalid = 1; bus_rdata = mem[{baddr[5:2], bbeat[1:0]}]; bbeat++;
        end else begin bst = 0; bcnt = 0; end
      end else if (bus_wvalid) begin
        mem[bcmd == 3'd3 ? baddr : {baddr[5:2], bbeat[1:0]}] = bus_wdata; bbeat++;
      end else begin bst = 0; bcnt = 0; end
    end
  end

  task automatic cpu(input logic [1:0] op, input logic [5:0] a, input logic [15:0] wd);
    @(negedge clk); cpu_req = 1; cpu_op = op; cpu_addr = a; cpu_wdata = wd; lat = 0;
    do begin @(negedge clk); lat++; end while (!cpu_ack && lat < 100);
    if (!cpu_ack) chk(0, "WATCHDOG", lat, 0);
    rd = cpu_rdata; cpu_req = 0;
    if (op == OP_WR) shadow[a] = wd;
  endtask

  task automatic snoop(input logic [2:0] c, input logic [5:0] a, input logic [15:0] wd);
    @(negedge clk); snp_valid = 1; snp_cmd = c; snp_addr = a[5:2];
    sup_base = {a[5:2], 2'b00}; sup_beats = 0; sup_bad = 0;
    if (c == 3'd3) begin mem[a] = wd; shadow[a] = wd; end
    @(negedge clk); snp_valid = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic blk_match(input logic [5:0] b, input string req);
    for (int k = 0; k < 4; k++) chk(mem[b + 6'(k)] == shadow[b + 6'(k)], req, int'(mem[b + 6'(k)]), int'(shadow[b + 6'(k)]));
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++; $display("FAIL WATCHDOG actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    int s, t; logic [5:0] b, a0, a1, a2, a3; logic [15:0] v; logic [1:0] ii, tg;
    for (int k = 0; k < 64; k++) begin mem[k] = 16'(k * 7 + 3); shadow[k] = 16'(k * 7 + 3); end
    for (int k = 0; k < 8; k++) n_cmd[k] = 0;
    repeat (3) @(negedge clk);
    chk(!cpu_ack && !bus_req && !snp_inhibit, "R1", int'({cpu_ack, bus_req, snp_inhibit}), 0);
    rst_n = 1;

    for (int i = 0; i < 4; i++) begin
      ii = 2'(i); tg = ii ^ 2'b10; b = {tg, ii, 2'b00};
      a0 = b; a1 = b + 6'd1; a2 = b + 6'd2; a3 = b + 6'd3; v = 16'(16'hA000 + i * 16);
      s = n_cmd[1]; cpu(OP_RD, a1, 0);
      chk(n_cmd[1] == s + 1, "R1", n_cmd[1] - s, 1);
      chk(rd == shadow[a1], "R9", int'(rd), int'(shadow[a1]));
      t = tot(); cpu(OP_RD, a2, 0);
      chk(rd == shadow[a2], "R9", int'(rd), int'(shadow[a2]));
      chk(lat == 1 && tot() == t, "R9", lat, 1);
      s = n_cmd[3]; cpu(OP_WR, a0, v);
      chk(n_cmd[3] == s + 1, "R4", n_cmd[3] - s, 1);
      chk(mem[a0] == v, "R4", int'(mem[a0]), int'(v));
      t = tot(); cpu(OP_WR, a0, v + 1);
      chk(lat == 1 && tot() == t, "R3", tot() - t, 0);
      cpu(OP_WR, a3, v + 2);
      chk(lat == 1 && tot() == t, "R3", tot() - t, 0);
      snoop(3'd1, a2, 0);
      chk(sup_beats == 4, "R2", sup_beats, 4);
      chk(sup_bad == 0, "R2", sup_bad, 0);
      blk_match(b, "R2");
      s = n_cmd[3]; cpu(OP_WR, a1, v + 3);
      chk(n_cmd[3] == s + 1, "R2", n_cmd[3] - s, 1);
      snoop(3'd1, a1, 0);
      chk(sup_beats == 0, "R11", sup_beats, 0);
      s = n_cmd[3]; cpu(OP_WR, a2, v + 4);
      chk(n_cmd[3] == s + 1, "R11", n_cmd[3] - s, 1);
      t = tot(); cpu(OP_EV, a0, 0);
      chk(tot() == t, "R6", tot() - t, 0);
      s = n_cmd[1]; cpu(OP_RD, a2, 0);
      chk(n_cmd[1] == s + 1 && rd == shadow[a2], "R6", int'(rd), int'(shadow[a2]));
      snoop(3'd3, {tg ^ 2'b01, ii, 2'b01}, 16'h5555);
      t = tot(); cpu(OP_RD, a1, 0);
      chk(tot() == t && rd == shadow[a1], "R10", int'(rd), int'(shadow[a1]));
      snoop(3'd3, a3, v + 5);
      s = n_cmd[1]; cpu(OP_RD, a3, 0);
      chk(n_cmd[1] == s + 1, "R7", n_cmd[1] - s, 1);
      chk(rd == v + 5, "R7", int'(rd), int'(v + 5));
      t = tot(); cpu(OP_EV, a0, 0);
      chk(tot() == t, "R6", tot() - t, 0);
      s = n_cmd[2]; cpu(OP_WR, a1, v + 6);
      chk(n_cmd[2] == s + 1, "R5", n_cmd[2] - s, 1);
      t = tot(); cpu(OP_WR, a0, v + 7);
      chk(tot() == t, "R5", tot() - t, 0);
      cpu(OP_RD, a2, 0);
      chk(rd == shadow[a2], "R5", int'(rd), int'(shadow[a2]));
      cpu(OP_RD, a1, 0);
      chk(rd == v + 6, "R5", int'(rd), int'(v + 6));
      snoop(3'd2, a0, 0);
      chk(sup_beats == 4 && sup_bad == 0, "R7", sup_beats, 4);
      s = n_cmd[1]; cpu(OP_RD, a0, 0);
      chk(n_cmd[1] == s + 1, "R7", n_cmd[1] - s, 1);
      chk(rd == v + 7, "R7", int'(rd), int'(v + 7));
      cpu(OP_WR, a3, v + 8);
      cpu(OP_WR, a3, v + 9);
      s = n_cmd[4]; cpu(OP_EV, a0, 0);
      chk(n_cmd[4] == s + 1, "R6", n_cmd[4] - s, 1);
      blk_match(b, "R6");
    end

    cpu(OP_RD, 6'd5, 0);
    @(negedge clk); cpu_req = 1; cpu_op = OP_RD; cpu_addr = 6'd5;
    snp_valid = 1; snp_cmd = 3'd1; snp_addr = 4'd1; lat = 0;
    @(negedge clk); snp_valid = 0; lat = 1;
    while (!cpu_ack && lat < 100) begin @(negedge clk); lat++; end
    chk(lat == 2, "R8", lat, 2);
    chk(cpu_rdata == shadow[5], "R8", int'(cpu_rdata), int'(shadow[5]));
    cpu_req = 0;
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule